// File: doc/BRIEF.md
# Threshold-Sensed In-Memory Logic Array

This block models a small array of single-bit cells, organised as rows of `COLS` bits, that serves both as an ordinary memory and as a bit-wise logic engine. A request carries two row addresses. When they match, or when the request is a plain read, the row decoder raises one word line. When they differ, it raises both lines at once. Each column then reports how many of its activated cells hold a one. A pair of threshold comparators turns that count into the result.

The "all-ones" comparator fires only when every activated cell in a column is 1, which yields AND. The "any-one" comparator fires when at least one activated cell is 1, which yields OR. NAND and NOR are the complemented outputs of these comparators. XOR is the NOR of the AND comparator and the NOR output. A separate read path serves plain reads. The operation code enables only the comparators that the operation needs, and an output select picks the final value.

The comparators are idle (precharged, output 0) except in the sample cycle that follows a request. The result is registered at the end of that cycle and marked by a one-cycle valid pulse. Writes store a row and produce no result.

Top module: `imla_array`

## Requirements
- R1: After reset `res_valid` and `res_data` are 0, and every stored row reads back as 0.
- R2: A request with `req_write`=1 stores `wr_data` in the row at `addr_a`. A later read of that row returns it.
- R3: A compute request (`req_valid`=1, `req_write`=0) accepted at clock edge k raises `res_valid` for exactly the cycle after edge k+1. A write request never raises `res_valid`.
- R4: Code 3'd1 (AND) returns the bit-wise AND of rows `addr_a` and `addr_b`. Code 3'd3 (OR) returns their bit-wise OR.
- R5: Code 3'd2 (NAND) and code 3'd4 (NOR) return the exact bit-wise complements of the AND and OR results.
- R6: Code 3'd5 (XOR) returns bits that are 1 where the two rows differ. Code 3'd6 (XNOR) returns the complement of XOR.
- R7: When `addr_a` equals `addr_b`, only one line is active. AND and OR then return that row, XOR returns 0, and XNOR returns all ones.
- R8: Code 3'd0 (READ) returns the row at `addr_a`, and `addr_b` has no effect.
- R9: A compute request issued in the cycle right after a write to one of its rows sees the newly written data.
- R10: Code 3'd7 is unused. It returns 0 with `res_valid` high.
- R11: `res_data` is 0 whenever `res_valid` is 0 (precharged sense outputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1: write `wr_data` to `addr_a`; 0: compute |
| req_op | input | 3 | Operation code (0 read, 1 AND, 2 NAND, 3 OR, 4 NOR, 5 XOR, 6 XNOR, 7 unused) |
| addr_a | input | AW | First row address (write target, read target) |
| addr_b | input | AW | Second row address |
| wr_data | input | COLS | Row data to store |
| res_valid | output | 1 | One-cycle pulse marking a result |
| res_data | output | COLS | Bit-wise result |

## Verification
Suppose the decoder fails to raise the second line, or raises it during a read. Then the AND, OR and XOR results, or a read on rows with distinct contents, differ from the expected row combination in the very result that follows. A wrong comparator threshold shows up at once when the two stored bits differ. A faulty sample-phase register shows as a valid pulse one cycle off, or as nonzero data outside the pulse, which is visible on the next idle cycle. Stored-row corruption shows on the next read of that row.

// File: rtl/imla_pkg.sv
package imla_pkg;

  typedef enum logic [2:0] {
    OP_READ = 3'd0,
    OP_AND  = 3'd1,
    OP_NAND = 3'd2,
    OP_OR   = 3'd3,
    OP_NOR  = 3'd4,
    OP_XOR  = 3'd5,
    OP_XNOR = 3'd6,
    OP_NONE = 3'd7
  } imla_op_e;

  typedef enum logic [1:0] {
    PICK_READ = 2'd0,
    PICK_ALL  = 2'd1,
    PICK_ANY  = 2'd2,
    PICK_DIFF = 2'd3
  } imla_pick_e;

  typedef struct packed {
    logic       en_read;
    logic       en_all;
    logic       en_any;
    imla_pick_e pick;
    logic       flip;
  } imla_ctrl_t;

  function automatic imla_ctrl_t imla_decode(input logic [2:0] code);
    imla_ctrl_t c;
    c = '{en_read: 1'b0, en_all: 1'b0, en_any: 1'b0, pick: PICK_READ, flip: 1'b0};
    case (imla_op_e'(code))
      OP_READ: c.en_read = 1'b1;
      OP_AND:  begin c.en_all = 1'b1; c.pick = PICK_ALL; end
      OP_NAND: begin c.en_all = 1'b1; c.pick = PICK_ALL; c.flip = 1'b1; end
      OP_OR:   begin c.en_any = 1'b1; c.pick = PICK_ANY; end
      OP_NOR:  begin c.en_any = 1'b1; c.pick = PICK_ANY; c.flip = 1'b1; end
      OP_XOR:  begin c.en_all = 1'b1; c.en_any = 1'b1; c.pick = PICK_DIFF; end
      OP_XNOR: begin c.en_all = 1'b1; c.en_any = 1'b1; c.pick = PICK_DIFF; c.flip = 1'b1; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/imla_decoder.sv
module imla_decoder #(
  parameter int ROWS = 16,
  parameter int AW   = 4
) (
  input  logic [AW-1:0]   addr_a,
  input  logic [AW-1:0]   addr_b,
  input  logic            single_only,
  output logic [ROWS-1:0] word_line,
  output logic [1:0]      line_count
);
  logic use_b;
  assign use_b = !single_only && (addr_a != addr_b);

  for (genvar r = 0; r < ROWS; r++) begin : g_line
    assign word_line[r] = (addr_a == AW'(r)) || (use_b && (addr_b == AW'(r)));
  end

  assign line_count = use_b ? 2'd2 : 2'd1;
endmodule

// File: rtl/imla_cell_array.sv
module imla_cell_array #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int AW   = 4,
  parameter int CW   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [COLS-1:0]         wr_data,
  input  logic                    sense_en,
  input  logic [ROWS-1:0]         word_line,
  output logic [COLS-1:0][CW-1:0] col_count_q
);
  logic [COLS-1:0] cells [ROWS];
  logic [COLS-1:0][CW-1:0] col_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_comb begin
      col_count[c] = '0;
      for (int r = 0; r < ROWS; r++)
        col_count[c] = col_count[c] + CW'(word_line[r] & cells[r][c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) col_count_q <= '0;
    else if (sense_en) col_count_q <= col_count;
  end
endmodule

// File: rtl/imla_sense.sv
module imla_sense #(
  parameter int COLS = 8,
  parameter int CW   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample,
  input  imla_pkg::imla_ctrl_t    ctrl,
  input  logic [1:0]              line_count,
  input  logic [COLS-1:0][CW-1:0] col_count,
  output logic                    res_valid,
  output logic [COLS-1:0]         res_data
);
  import imla_pkg::*;

  logic [COLS-1:0] col_out;

  for (genvar c = 0; c < COLS; c++) begin : g_cmp
    logic hit_all, hit_any, hit_read, picked;
    always_comb begin
      hit_all  = sample && ctrl.en_all  && (col_count[c] >= CW'(line_count));
      hit_any  = sample && ctrl.en_any  && (col_count[c] != '0);
      hit_read = sample && ctrl.en_read && (col_count[c] != '0);
      unique case (ctrl.pick)
        PICK_READ: picked = hit_read;
        PICK_ALL:  picked = hit_all;
        PICK_ANY:  picked = hit_any;
        PICK_DIFF: picked = !(hit_all || !hit_any);
      endcase
      col_out[c] = sample && (picked ^ ctrl.flip);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= sample;
      res_data  <= col_out;
    end
  end
endmodule

// File: rtl/imla_array.sv
module imla_array #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  parameter int AW   = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   addr_a,
  input  logic [AW-1:0]   addr_b,
  input  logic [COLS-1:0] wr_data,
  output logic            res_valid,
  output logic [COLS-1:0] res_data
);
  import imla_pkg::*;

  localparam int CW = 2;

  logic                    do_write, do_compute;
  logic [ROWS-1:0]         word_line;
  logic [1:0]              line_count;
  logic [COLS-1:0][CW-1:0] col_count_q;
  logic                    sample_q;
  imla_ctrl_t              ctrl_q;
  logic [1:0]              lines_q;

  assign do_write   = req_valid && req_write;
  assign do_compute = req_valid && !req_write;

  imla_decoder #(.ROWS(ROWS), .AW(AW)) u_dec (
    .addr_a      (addr_a),
    .addr_b      (addr_b),
    .single_only (req_op == OP_READ),
    .word_line   (word_line),
    .line_count  (line_count)
  );

  imla_cell_array #(.ROWS(ROWS), .COLS(COLS), .AW(AW), .CW(CW)) u_cells (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (do_write),
    .wr_addr     (addr_a),
    .wr_data     (wr_data),
    .sense_en    (do_compute),
    .word_line   (word_line),
    .col_count_q (col_count_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= 1'b0;
      ctrl_q   <= '0;
      lines_q  <= 2'd1;
    end else begin
      sample_q <= do_compute;
      if (do_compute) begin
        ctrl_q  <= imla_decode(req_op);
        lines_q <= line_count;
      end
    end
  end

  imla_sense #(.COLS(COLS), .CW(CW)) u_sense (
    .clk        (clk),
    .rst        (rst),
    .sample     (sample_q),
    .ctrl       (ctrl_q),
    .line_count (lines_q),
    .col_count  (col_count_q),
    .res_valid  (res_valid),
    .res_data   (res_data)
  );
endmodule

// File: rtl/imla_array_checker.sv
module imla_array_checker #(
  parameter int COLS = 8,
  parameter int AW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic [2:0]      req_op,
  input logic [AW-1:0]   addr_a,
  input logic [AW-1:0]   addr_b,
  input logic            res_valid,
  input logic [COLS-1:0] res_data
);
  logic       v1, v2, same1, same2;
  logic [2:0] op1, op2;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; same1 <= 1'b0; same2 <= 1'b0;
      op1 <= 3'd0; op2 <= 3'd0;
    end else begin
      v1    <= req_valid && !req_write;
      op1   <= req_op;
      same1 <= (addr_a == addr_b);
      v2    <= v1;
      op2   <= op1;
      same2 <= same1;
    end
  end

  // R3: result pulse follows a compute request by two edges, never a write
  a_r3_valid_timing: assert property (@(posedge clk) disable iff (rst)
    res_valid == v2);

  // R11: precharged outputs read as zero outside the pulse
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (res_data == '0));

  // R10: unused code returns zero
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && v2 && op2 == 3'd7) |-> (res_data == '0));

  // R7: one active line makes XOR zero
  a_r7_same_xor_zero: assert property (@(posedge clk) disable iff (rst)
    (res_valid && same2 && op2 == 3'd5) |-> (res_data == '0));

  // R7: one active line makes XNOR all ones
  a_r7_same_xnor_ones: assert property (@(posedge clk) disable iff (rst)
    (res_valid && same2 && op2 == 3'd6) |-> (res_data == '1));
endmodule

bind imla_array imla_array_checker #(.COLS(COLS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_op    (req_op),
  .addr_a    (addr_a),
  .addr_b    (addr_b),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/imla_array_bench.sv
module imla_array_bench;
  localparam int ROWS = 16;
  localparam int COLS = 8;
  localparam int AW   = 4;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_write = 1'b0;
  logic [2:0]      req_op = 3'd0;
  logic [AW-1:0]   addr_a = '0;
  logic [AW-1:0]   addr_b = '0;
  logic [COLS-1:0] wr_data = '0;
  logic            res_valid;
  logic [COLS-1:0] res_data;

  int checks = 0;
  int fails  = 0;
  logic [COLS-1:0] shadow [ROWS];

  always #(CLK_PERIOD/2) clk = ~clk;

  imla_array #(.ROWS(ROWS), .COLS(COLS)) u_imla_array (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_op(req_op), .addr_a(addr_a), .addr_b(addr_b), .wr_data(wr_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(input string req, input logic [COLS:0] got, input logic [COLS:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [COLS-1:0] model(input logic [2:0] op, input int a, input int b);
    logic [COLS-1:0] x, y;
    x = shadow[a];
    y = shadow[b];
    case (op)
      3'd0: return x;
      3'd1: return x & y;
      3'd2: return ~(x & y);
      3'd3: return x | y;
      3'd4: return ~(x | y);
      3'd5: return x ^ y;
      3'd6: return ~(x ^ y);
      default: return '0;
    endcase
  endfunction

  task automatic write_row(input int a, input logic [COLS-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; addr_a = AW'(a); wr_data = d;
    shadow[a] = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R3 no pulse after write", {res_valid, {COLS{1'b0}}}, '0);
  endtask

  task automatic compute(input string req, input logic [2:0] op, input int a, input int b);
    logic [COLS-1:0] exp;
    exp = model(op, a, b);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_op = op; addr_a = AW'(a); addr_b = AW'(b);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " R3 not early"}, {res_valid, {COLS{1'b0}}}, '0);
    @(negedge clk);
    check(req, {res_valid, res_data}, {1'b1, exp});
    @(negedge clk);
    check({req, " R3 R11 pulse ends"}, {res_valid, res_data}, '0);
  endtask

  task automatic t_reset;
    check("R1 reset outputs", {res_valid, res_data}, '0);
    for (int r = 0; r < ROWS; r += 5) compute("R1 rows cleared", 3'd0, r, 0);
  endtask

  task automatic t_write_read;
    write_row(2, 8'hA5);
    write_row(3, 8'h3C);
    write_row(9, 8'hFF);
    compute("R2 read row 2", 3'd0, 2, 0);
    compute("R2 read row 9", 3'd0, 9, 0);
  endtask

  task automatic t_basic_logic;
    compute("R4 AND", 3'd1, 2, 3);
    compute("R4 OR", 3'd3, 2, 3);
    compute("R4 AND with ones row", 3'd1, 9, 3);
    compute("R5 NAND", 3'd2, 2, 3);
    compute("R5 NOR", 3'd4, 2, 3);
    compute("R6 XOR", 3'd5, 2, 3);
    compute("R6 XNOR", 3'd6, 3, 2);
  endtask

  task automatic t_same_addr;
    compute("R7 AND single line", 3'd1, 2, 2);
    compute("R7 OR single line", 3'd3, 2, 2);
    compute("R7 XOR single line", 3'd5, 3, 3);
    compute("R7 XNOR single line", 3'd6, 3, 3);
  endtask

  task automatic t_read_ignores_b;
    compute("R8 read ignores addr_b", 3'd0, 3, 9);
    compute("R8 read ignores addr_b zero row", 3'd0, 0, 9);
  endtask

  task automatic t_back_to_back;
    logic [COLS-1:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; addr_a = AW'(5); wr_data = 8'h96;
    shadow[5] = 8'h96;
    exp = shadow[5] ^ shadow[3];
    @(negedge clk);
    req_write = 1'b0; req_op = 3'd5; addr_a = AW'(5); addr_b = AW'(3);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 compute sees fresh write", {res_valid, res_data}, {1'b1, exp});
    @(negedge clk);
  endtask

  task automatic t_unused;
    compute("R10 unused code", 3'd7, 9, 9);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) shadow[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_basic_logic();
    t_same_addr();
    t_read_ignores_b();
    t_back_to_back();
    t_unused();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule